// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block drives one multiplexed 12-bit converter across a contiguous run of input channels. Software reaches it through a byte-wide register bus. The registers hold the scan window, a gain code for each channel, a control byte, a status byte, and a two-byte result. A conversion starts on one of three events, chosen by the control byte: a bus write, a pulse on an external trigger pin, or a tick from an external pacer. When a conversion finishes, the result is latched together with the channel it came from. The block then moves to the next channel of the window and raises a data-ready flag. That flag drives either an interrupt line or a DMA request line.

Software can build a per-channel gain list. It points the mux at a single channel, writes that channel's gain, and repeats for the next channel. It then programs the real scan window and selects a trigger source. The converter is a behavioural stub. Its value depends only on the channel and that channel's gain, so the returned data can be predicted.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the trigger source is off, the scan window is channel 0 to channel 0, every gain code is 0, and the ready and busy flags are clear. With singleEnded=1 and unipolar=0 the status byte reads 0x20.
- R2: A write to address 2 sets the first channel from bits 3:0 and the last channel from bits 7:4. The same write makes the first channel the current channel. A read of address 2 returns the stored byte.
- R3: A write to address 1 stores bits 3:0 as the gain code of the current channel only.
- R4: Control byte (address 4, readable) bits 1:0 pick the trigger: 0 off, 1 bus write to address 0, 2 extTrig, 3 pacerTick. A start event from any source that is not selected causes no conversion.
- R5: A conversion finishes CONV_CYCLES clock edges after the edge that accepted its trigger. Its result word has the channel in bits 3:0 and the sample in bits 15:4. The sample is {gain[3:0], chan[3:0], chan[3:0]^4'hA}. Address 0 reads the low byte and address 1 reads the high byte.
- R6: After each conversion the current channel advances by one. When the current channel is the last channel, the next one is the first channel.
- R7: The active channel count is 16 when singleEnded=1 and 8 otherwise. A channel equal to the count minus one is followed by channel 0.
- R8: Status byte (address 3) layout: bits 3:0 current channel, bit 4 ready, bit 5 singleEnded, bit 6 unipolar, bit 7 busy.
- R9: A write of any value to address 3 clears ready. A conversion that finishes on the same edge keeps ready set.
- R10: With control bit 2 set, dmaReq follows ready and irqOut stays low. With bit 2 clear, irqOut equals ready AND control bit 7. irqNum shows control bits 6:4.
- R11: A trigger that arrives while a conversion is busy is dropped. It neither restarts nor lengthens the conversion, and it adds no channel advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| singleEnded | input | 1 | Input mode strap: 1 single-ended, 0 differential |
| unipolar | input | 1 | Polarity strap, shown in status |
| extTrig | input | 1 | External conversion trigger pulse |
| pacerTick | input | 1 | Pacer conversion tick |
| irqOut | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |
| irqNum | output | 3 | Selected interrupt number |

## Verification
The checker watches every cycle for five things: the conversion length measured from its start strobe, ready rising at each finish, ready falling on a status write with no finish in the same cycle, no start strobe while busy, and a return to the first channel after the last. It also checks that the interrupt and DMA request never assert together. The bench scenarios show the parts that depend on register contents. These are the gain list loaded per channel, the packing of the result bytes, the wrap at 8 channels in differential mode, and the rejection of unselected trigger sources. Randomly chosen scan windows and gain tables are compared against a channel model kept in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef struct packed {
    logic startConv;
    logic finishConv;
    logic clearReady;
    logic wrMux;
    logic wrGain;
    logic wrCtrl;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_SW   = 2'd1,
    TRIG_EXT  = 2'd2,
    TRIG_PACE = 2'd3
  } trigSel_t;

  localparam logic [2:0] ADDR_DATA_LO = 3'd0;
  localparam logic [2:0] ADDR_DATA_HI = 3'd1;
  localparam logic [2:0] ADDR_MUX     = 3'd2;
  localparam logic [2:0] ADDR_STATUS  = 3'd3;
  localparam logic [2:0] ADDR_CTRL    = 3'd4;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  trigSel_t   trigSrc,
  input  logic       extTrig,
  input  logic       pacerTick,
  output seqStrobe_t strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             trigHit;

  always_comb begin
    case (trigSrc)
      TRIG_SW:   trigHit = busWr && (busAddr == ADDR_DATA_LO);
      TRIG_EXT:  trigHit = extTrig;
      TRIG_PACE: trigHit = pacerTick;
      default:   trigHit = 1'b0;
    endcase
    strb.startConv  = trigHit && !busy;
    strb.finishConv = busy && (cnt == '0);
    strb.clearReady = busWr && (busAddr == ADDR_STATUS);
    strb.wrMux      = busWr && (busAddr == ADDR_MUX);
    strb.wrGain     = busWr && (busAddr == ADDR_DATA_HI);
    strb.wrCtrl     = busWr && (busAddr == ADDR_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.startConv) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CONV_CYCLES - 1);
    end else if (strb.finishConv) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int GAIN_W   = 4,
  parameter int SAMPLE_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic                      busy,
  input  logic [2:0]                busAddr,
  input  logic [7:0]                busWrData,
  input  logic                      singleEnded,
  input  logic                      unipolar,
  output logic [7:0]                busRdData,
  output trigSel_t                  trigSrc,
  output logic                      irqOut,
  output logic                      dmaReq,
  output logic [2:0]                irqNum,
  output logic [$clog2(NUM_CH)-1:0] curChan,
  output logic [$clog2(NUM_CH)-1:0] muxFirst,
  output logic [$clog2(NUM_CH)-1:0] muxLast,
  output logic                      readyFlag
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int STUB_W = GAIN_W + 2 * CH_W;
  localparam int RES_W  = SAMPLE_W + CH_W;

  logic [GAIN_W-1:0]   gainTbl [NUM_CH];
  logic [7:0]          ctrlReg;
  logic [CH_W-1:0]     convChan;
  logic [CH_W-1:0]     nextChan;
  logic [CH_W:0]       incChan;
  logic [CH_W:0]       activeCount;
  logic [STUB_W-1:0]   stubRaw;
  logic [SAMPLE_W-1:0] adcValue;
  logic [15:0]         result;
  logic [7:0]          statusByte;

  // Per-channel gain table
  for (genvar g = 0; g < NUM_CH; g++) begin : g_gain
    always_ff @(posedge clk) begin
      if (!rstN) gainTbl[g] <= '0;
      else if (strb.wrGain && curChan == CH_W'(g)) gainTbl[g] <= busWrData[GAIN_W-1:0];
    end
  end

  // Behavioural converter stub
  assign stubRaw  = {gainTbl[convChan], convChan, convChan ^ CH_W'(10)};
  assign adcValue = SAMPLE_W'(stubRaw);

  // Channel advance with window wrap and active-count wrap
  always_comb begin
    incChan     = {1'b0, curChan} + 1'b1;
    activeCount = singleEnded ? (CH_W+1)'(NUM_CH) : (CH_W+1)'(NUM_CH / 2);
    if (curChan == muxLast)        nextChan = muxFirst;
    else if (incChan >= activeCount) nextChan = '0;
    else                           nextChan = incChan[CH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxFirst  <= '0;
      muxLast   <= '0;
      curChan   <= '0;
      convChan  <= '0;
      ctrlReg   <= '0;
      result    <= '0;
      readyFlag <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= busWrData;
      if (strb.startConv) convChan <= curChan;
      if (strb.wrMux) begin
        muxFirst <= busWrData[CH_W-1:0];
        muxLast  <= busWrData[4 +: CH_W];
        curChan  <= busWrData[CH_W-1:0];
      end else if (strb.finishConv) begin
        curChan <= nextChan;
      end
      if (strb.finishConv) begin
        result    <= 16'({adcValue, convChan});
        readyFlag <= 1'b1;
      end else if (strb.clearReady) begin
        readyFlag <= 1'b0;
      end
    end
  end

  assign trigSrc    = trigSel_t'(ctrlReg[1:0]);
  assign irqNum     = ctrlReg[6:4];
  assign dmaReq     = readyFlag && ctrlReg[2];
  assign irqOut     = readyFlag && ctrlReg[7] && !ctrlReg[2];
  assign statusByte = {busy, unipolar, singleEnded, readyFlag, 4'(curChan)};

  always_comb begin
    case (busAddr)
      ADDR_DATA_LO: busRdData = result[7:0];
      ADDR_DATA_HI: busRdData = result[15:8];
      ADDR_MUX:     busRdData = {4'(muxLast), 4'(muxFirst)};
      ADDR_STATUS:  busRdData = statusByte;
      ADDR_CTRL:    busRdData = ctrlReg;
      default:      busRdData = 8'h00;
    endcase
  end

  logic unusedRes;
  assign unusedRes = ^RES_W;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int GAIN_W      = 4,
  parameter int SAMPLE_W    = 12,
  parameter int CONV_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       singleEnded,
  input  logic       unipolar,
  input  logic       extTrig,
  input  logic       pacerTick,
  output logic       irqOut,
  output logic       dmaReq,
  output logic [2:0] irqNum
);
  localparam int CH_W = $clog2(NUM_CH);

  seqStrobe_t      strb;
  trigSel_t        trigSrc;
  logic            busy;
  logic            readyFlag;
  logic [CH_W-1:0] curChan;
  logic [CH_W-1:0] muxFirst;
  logic [CH_W-1:0] muxLast;

  adc_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .trigSrc(trigSrc), .extTrig(extTrig), .pacerTick(pacerTick),
    .strb(strb), .busy(busy)
  );

  adc_seq_dp #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .busAddr(busAddr),
    .busWrData(busWrData), .singleEnded(singleEnded), .unipolar(unipolar),
    .busRdData(busRdData), .trigSrc(trigSrc), .irqOut(irqOut), .dmaReq(dmaReq),
    .irqNum(irqNum), .curChan(curChan), .muxFirst(muxFirst), .muxLast(muxLast),
    .readyFlag(readyFlag)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 4,
  parameter int CH_W        = 4
) (
  input logic            clk,
  input logic            rstN,
  input seqStrobe_t      strb,
  input logic            busy,
  input logic            readyFlag,
  input logic [CH_W-1:0] curChan,
  input logic [CH_W-1:0] muxFirst,
  input logic [CH_W-1:0] muxLast,
  input logic            irqOut,
  input logic            dmaReq
);
  int unsigned sinceStart;

  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= 0;
    else if (strb.startConv) sinceStart <= 1;
    else if (strb.finishConv) sinceStart <= 0;
    else if (sinceStart != 0) sinceStart <= sinceStart + 1;
  end

  // R5
  conv_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishConv |-> sinceStart == CONV_CYCLES);

  // R5
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishConv |=> readyFlag);

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearReady && !strb.finishConv) |=> !readyFlag);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finishConv) |-> !strb.startConv);

  // R6
  window_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishConv && !strb.wrMux && curChan == muxLast) |=> curChan == $past(muxFirst));

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && dmaReq));
endmodule

bind adc_scan_seq adc_seq_chk #(.CONV_CYCLES(CONV_CYCLES), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .readyFlag(readyFlag),
  .curChan(curChan), .muxFirst(muxFirst), .muxLast(muxLast),
  .irqOut(irqOut), .dmaReq(dmaReq)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       singleEnded = 1'b1;
  logic       unipolar = 1'b0;
  logic       extTrig = 1'b0;
  logic       pacerTick = 1'b0;
  logic       irqOut, dmaReq;
  logic [2:0] irqNum;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [3:0] gainModel [16];
  logic [3:0] mFirst, mLast, mCur;

  adc_scan_seq #(.CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .singleEnded(singleEnded), .unipolar(unipolar),
    .extTrig(extTrig), .pacerTick(pacerTick), .irqOut(irqOut), .dmaReq(dmaReq),
    .irqNum(irqNum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expWord(logic [3:0] ch, logic [3:0] g);
    return {g, ch, ch ^ 4'hA, ch};
  endfunction

  function automatic logic [3:0] nextOf(logic [3:0] c, logic [3:0] f, logic [3:0] l, bit se);
    int lim = se ? 16 : 8;
    if (c == l) return f;
    if (int'(c) + 1 >= lim) return 4'd0;
    return c + 4'd1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic setMux(logic [3:0] f, logic [3:0] l);
    wr(3'd2, {l, f});
    mFirst = f; mLast = l; mCur = f;
  endtask

  task automatic waitConv();
    repeat (CONV + 1) @(negedge clk);
  endtask

  task automatic readResult(output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    w = {hi, lo};
  endtask

  // soft-triggered conversion compared against the model, then cleared
  task automatic softConvCheck(string req);
    logic [15:0] w;
    wr(3'd0, 8'h00);
    waitConv();
    readResult(w);
    check(req, w, expWord(mCur, gainModel[mCur]));
    mCur = nextOf(mCur, mFirst, mLast, singleEnded);
    wr(3'd3, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    int seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 16; i++) gainModel[i] = 4'd0;
    mFirst = 0; mLast = 0; mCur = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R8 status layout
    rd(3'd3, v); check("R1 status after reset", v, 8'h20);
    rd(3'd4, v); check("R1 ctrl after reset", v, 8'h00);
    rd(3'd2, v); check("R1 mux after reset", v, 8'h00);
    check("R1 irqOut after reset", irqOut, 0);

    // R4 soft write with trigger off: no conversion
    wr(3'd0, 8'h00);
    waitConv();
    rd(3'd3, v); check("R4 trigger off ignores soft start", v, 8'h20);

    // R1 gains zero: convert channel 0 under software trigger
    wr(3'd4, 8'h01);
    softConvCheck("R1 gain zero / R5 result format");

    // R3 load gain list by alternating mux and gain writes
    for (int c = 0; c < 16; c++) begin
      logic [3:0] g;
      g = 4'(c * 7 + 3);
      setMux(4'(c), 4'(c));
      wr(3'd1, {4'hF, g});
      gainModel[c] = g;
    end

    // R2 mux format and readback
    setMux(4'd2, 4'd4);
    rd(3'd2, v); check("R2 mux readback", v, 8'h42);
    rd(3'd3, v); check("R2 current = first", v[3:0], 2);

    // R5 busy during conversion, R8 busy bit
    wr(3'd0, 8'h00);
    rd(3'd3, v); check("R8 busy bit during conversion", v[7], 1);
    waitConv();
    rd(3'd3, v); check("R8 ready and next channel", v, 8'h33);
    readResult(w); check("R5 channel 2 result", w, expWord(4'd2, gainModel[2]));
    mCur = 4'd3;
    wr(3'd3, 8'h55);
    rd(3'd3, v); check("R9 status write clears ready", v[4], 0);

    // R6 window wrap 3,4,2,3
    softConvCheck("R6 scan ch3");
    softConvCheck("R6 scan ch4");
    softConvCheck("R6 wrap to first ch2");
    rd(3'd3, v); check("R6 current after wrap", v[3:0], 3);

    // R7 differential wrap 6,7,0,1,6
    singleEnded = 1'b0;
    setMux(4'd6, 4'd1);
    rd(3'd3, v); check("R8 differential bit", v[5], 0);
    softConvCheck("R7 diff ch6");
    softConvCheck("R7 diff ch7");
    softConvCheck("R7 diff wrap to 0");
    softConvCheck("R7 diff ch1");
    softConvCheck("R7 diff back to first");
    singleEnded = 1'b1;

    // R7 single-ended window crossing 15
    setMux(4'd15, 4'd1);
    softConvCheck("R7 se ch15");
    softConvCheck("R7 se wrap to 0");

    // R11 second trigger while busy dropped
    setMux(4'd5, 4'd9);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h00);
    waitConv();
    rd(3'd3, v); check("R11 one advance only", v[3:0], 6);
    readResult(w); check("R11 result ch5", w, expWord(4'd5, gainModel[5]));
    wr(3'd3, 8'h00);
    mCur = 4'd6;

    // R4 external trigger selected; pacer and soft writes ignored
    wr(3'd4, 8'h02);
    @(negedge clk); pacerTick = 1'b1; @(negedge clk); pacerTick = 1'b0;
    wr(3'd0, 8'h00);
    waitConv();
    rd(3'd3, v); check("R4 unselected sources ignored", v, 8'h26);
    @(negedge clk); extTrig = 1'b1; @(negedge clk); extTrig = 1'b0;
    waitConv();
    readResult(w); check("R4 ext trigger result", w, expWord(4'd6, gainModel[6]));
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h03);
    @(negedge clk); pacerTick = 1'b1; @(negedge clk); pacerTick = 1'b0;
    waitConv();
    readResult(w); check("R4 pacer trigger result", w, expWord(4'd7, gainModel[7]));
    wr(3'd3, 8'h00);
    mCur = 4'd8;

    // R10 interrupt path
    wr(3'd4, 8'hD1);
    check("R10 irqNum", irqNum, 5);
    softConvCheck("R10 conversion with irq");
    check("R10 irq cleared", irqOut, 0);
    wr(3'd0, 8'h00);
    waitConv();
    check("R10 irqOut raised", irqOut, 1);
    check("R10 dmaReq low", dmaReq, 0);
    wr(3'd3, 8'h00);
    check("R9 irq cleared by status write", irqOut, 0);
    mCur = nextOf(mCur, mFirst, mLast, 1'b1);
    // R10 DMA path
    wr(3'd4, 8'h85);
    wr(3'd0, 8'h00);
    waitConv();
    check("R10 dmaReq raised", dmaReq, 1);
    check("R10 irqOut masked by dma", irqOut, 0);
    wr(3'd3, 8'h00);
    mCur = nextOf(mCur, mFirst, mLast, 1'b1);
    wr(3'd4, 8'h01);

    // R6 R3 R5 random windows and gains
    for (int it = 0; it < 30; it++) begin
      logic [3:0] f, l, c, g;
      int n;
      c = 4'($urandom_range(0, 15));
      g = 4'($urandom_range(0, 15));
      setMux(c, c);
      wr(3'd1, {4'h0, g});
      gainModel[c] = g;
      f = 4'($urandom_range(0, 15));
      l = 4'($urandom_range(0, 15));
      setMux(f, l);
      n = $urandom_range(1, 5);
      for (int k = 0; k < n; k++) softConvCheck("R6 random scan");
      rd(3'd3, v); check("R6 random next channel", v[3:0], mCur);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule